// File: doc/BRIEF.md
# TDC acquisition and fast-clear sequencer

This block sequences one acquisition cycle of a multihit time digitizer. In common-start mode a rising edge on the common input opens a measurement. The measurement ends either after a programmed full-scale count of clock cycles or on a rising edge of an external time-out input, selected by a configuration bit. In common-stop mode the rising edge on the common input ends the measurement at once.

When the measurement ends, two things start together. The first is a conversion phase whose length grows with the number of hits reported by the digitizer. The second is a fast-clear window whose length is programmed in 1024 ns units. A rising edge on the fast-clear input while the window is open aborts the event. If the window and the conversion both finish without such an edge, the event is committed.

The block drives `busy`, the window state and one-cycle commit and abort strobes. Digitizing and buffering the hit data belong to neighbouring blocks. All timing assumes an 8 ns clock (parameter `CLK_NS`).

Top module: `tdc_acq_sequencer`

## Requirements
- R1: While reset is held and just after it, `busy` (with `buf_full` low), `clear_window`, `event_commit` and `event_abort` are all 0.
- R2: In common-start mode (`stop_mode`=0) with `ext_timeout_sel`=0, a common rising edge sampled at clock edge t0 ends the measurement at edge t0+`full_scale_cfg`+1. `clear_window` reads 1 from that edge on and reads 0 before it.
- R3: With `ext_timeout_sel`=1 in common-start mode, the internal count has no effect. The measurement ends at the clock edge that samples a rising edge of `ext_timeout_in`.
- R4: In common-stop mode (`stop_mode`=1) a common rising edge ends the measurement at the same clock edge that samples it.
- R5: Conversion lasts max(219, ceil((1200 + 50*h)/8)) clock cycles, where h is `hit_count` sampled at the end of the measurement. `busy` is 1 for exactly those cycles.
- R6: The window lasts u*128 clock cycles, where u = `window_cfg`, and both 0 and 1 give u=1. `clear_window` is 1 for exactly those cycles, starting at the end of the measurement.
- R7: A fast-clear rising edge sampled while the window is open gives a one-cycle `event_abort` at that edge and cancels the conversion, so `busy` drops. A new common edge is accepted on the very next cycle.
- R8: A fast-clear rising edge outside the window is ignored, and so is a fast-clear level that was already high when the window opened (the input is edge sensitive).
- R9: When both window and conversion have ended without an abort, `event_commit` pulses for one cycle on the following clock edge. Commit and abort never occur together, and each completed event yields exactly one of them.
- R10: `busy` is 1 whenever `buf_full` is 1.
- R11: Common edges are ignored while a measurement, conversion or window is in progress, and while `buf_full` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 8 ns period assumed |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 1 | 0: common start, 1: common stop |
| ext_timeout_sel | input | 1 | 1: full scale ends on `ext_timeout_in` edge |
| full_scale_cfg | input | FS_W (12) | Internal full-scale count, cycles minus one |
| window_cfg | input | WIN_CFG_W (9) | Fast-clear window length in 1024 ns units |
| hit_count | input | HIT_W (11) | Hits recorded within full scale for this event |
| common_in | input | 1 | Common start/stop input, rising edge active |
| ext_timeout_in | input | 1 | External time-out, rising edge active |
| fast_clear_in | input | 1 | Fast clear, rising edge active |
| buf_full | input | 1 | Downstream event buffer full |
| busy | output | 1 | Converting or buffer full |
| clear_window | output | 1 | Fast-clear window open |
| event_commit | output | 1 | One-cycle strobe: keep the event |
| event_abort | output | 1 | One-cycle strobe: discard the event |

## Verification
A fast clear and the close of the window can meet in one cycle. A fast clear can also arrive on the exact edge at which the conversion ends. The bench raises the fast-clear input one cycle ahead of each such edge: the last open window cycle, the first closed one, and the last conversion cycle with the window still open. The scoreboard then expects an abort at that edge in the first and third case, and a commit one edge later in the second. Any extra or missing strobe, or a strobe one cycle off, is reported.

// File: rtl/tdcseq_pkg.sv
package tdcseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MEAS = 2'd1,
        PH_POST = 2'd2
    } phase_e;

    // Bundle of edge-sensitive inputs; common is bit 0.
    typedef struct packed {
        logic fclr;
        logic ext_to;
        logic common;
    } trig_t;

    localparam int TRIG_N = $bits(trig_t);

    function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Conversion duration in clock cycles for a given hit count.
    function automatic int unsigned conv_len(int unsigned hits, int unsigned base_ns,
                                             int unsigned hit_ns, int unsigned min_ns,
                                             int unsigned clk_ns);
        int unsigned raw_c;
        int unsigned floor_c;
        raw_c   = ceil_div(base_ns + hit_ns * hits, clk_ns);
        floor_c = ceil_div(min_ns, clk_ns);
        return (raw_c < floor_c) ? floor_c : raw_c;
    endfunction

    // Window units: 0 and 1 both mean one unit.
    function automatic int unsigned win_units(int unsigned cfg);
        return (cfg < 2) ? 1 : cfg;
    endfunction

endpackage

// File: rtl/tdcseq_edge.sv
module tdcseq_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;
        // Reset to 1 so a level already high at reset release is not an edge.
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b1;
            else     prev_q <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q;
    end
endmodule

// File: rtl/tdcseq_downcnt.sv
module tdcseq_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         running,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt_q   <= load_val;
        end else if (running) begin
            if (cnt_q == '0) running <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign last = running && (cnt_q == '0);
endmodule

// File: rtl/tdc_acq_sequencer.sv
module tdc_acq_sequencer
    import tdcseq_pkg::*;
#(
    parameter int CLK_NS       = 8,
    parameter int FS_W         = 12,
    parameter int WIN_CFG_W    = 9,
    parameter int HIT_W        = 11,
    parameter int UNIT_NS      = 1024,
    parameter int CONV_BASE_NS = 1200,
    parameter int CONV_HIT_NS  = 50,
    parameter int CONV_MIN_NS  = 1750
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stop_mode,
    input  logic                 ext_timeout_sel,
    input  logic [FS_W-1:0]      full_scale_cfg,
    input  logic [WIN_CFG_W-1:0] window_cfg,
    input  logic [HIT_W-1:0]     hit_count,
    input  logic                 common_in,
    input  logic                 ext_timeout_in,
    input  logic                 fast_clear_in,
    input  logic                 buf_full,
    output logic                 busy,
    output logic                 clear_window,
    output logic                 event_commit,
    output logic                 event_abort
);
    localparam int unsigned UNIT_CYC     = UNIT_NS / CLK_NS;
    localparam int unsigned CONV_MAX_CYC = conv_len(2**HIT_W - 1, CONV_BASE_NS, CONV_HIT_NS,
                                                    CONV_MIN_NS, CLK_NS);
    localparam int          CONV_W       = $clog2(CONV_MAX_CYC + 1);
    localparam int unsigned WIN_MAX_CYC  = UNIT_CYC * (2**WIN_CFG_W - 1);
    localparam int          WIN_W        = $clog2(WIN_MAX_CYC + 1);

    // Edge detection on the trigger inputs
    trig_t lvl_s;
    trig_t rise_s;

    assign lvl_s.fclr   = fast_clear_in;
    assign lvl_s.ext_to = ext_timeout_in;
    assign lvl_s.common = common_in;

    tdcseq_edge #(.N(TRIG_N)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl_s),
        .rise (rise_s)
    );

    // Phase control
    phase_e phase_q, phase_d;
    logic   start_ok, meas_begin, meas_end, abort_now, commit_now;
    logic   meas_run, meas_last, conv_run, conv_last, win_run, win_last;
    logic [CONV_W-1:0] conv_load;
    logic [WIN_W-1:0]  win_load;

    assign start_ok   = (phase_q == PH_IDLE) && rise_s.common && !buf_full;
    assign meas_begin = start_ok && !stop_mode;
    assign meas_end   = (start_ok && stop_mode) ||
                        ((phase_q == PH_MEAS) &&
                         (ext_timeout_sel ? rise_s.ext_to : meas_last));
    assign abort_now  = (phase_q == PH_POST) && win_run && rise_s.fclr;
    assign commit_now = (phase_q == PH_POST) && !win_run && !conv_run;

    assign conv_load = CONV_W'(conv_len(int'(hit_count), CONV_BASE_NS, CONV_HIT_NS,
                                        CONV_MIN_NS, CLK_NS) - 1);
    assign win_load  = WIN_W'(win_units(int'(window_cfg)) * UNIT_CYC - 1);

    tdcseq_downcnt #(.W(FS_W)) u_meas_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (meas_end),
        .load     (meas_begin),
        .load_val (full_scale_cfg),
        .running  (meas_run),
        .last     (meas_last)
    );

    tdcseq_downcnt #(.W(CONV_W)) u_conv_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (abort_now),
        .load     (meas_end),
        .load_val (conv_load),
        .running  (conv_run),
        .last     (conv_last)
    );

    tdcseq_downcnt #(.W(WIN_W)) u_win_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (abort_now),
        .load     (meas_end),
        .load_val (win_load),
        .running  (win_run),
        .last     (win_last)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (meas_end)        phase_d = PH_POST;
                else if (meas_begin) phase_d = PH_MEAS;
            end
            PH_MEAS: if (meas_end) phase_d = PH_POST;
            PH_POST: if (abort_now || commit_now) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            event_commit <= 1'b0;
            event_abort  <= 1'b0;
        end else begin
            phase_q      <= phase_d;
            event_commit <= commit_now;
            event_abort  <= abort_now;
        end
    end

    assign busy         = conv_run | buf_full;
    assign clear_window = win_run;

    // Assertions
    assert_commit_abort_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(event_commit && event_abort));

    assert_abort_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        event_abort |-> ($past(clear_window) && $past(fast_clear_in)));

    assert_commit_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        event_commit |-> (!$past(clear_window) && !$past(conv_run)));

    assert_busy_when_full_R10: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> busy);

    assert_window_opens_from_meas_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(clear_window) |-> ($past(phase_q) != PH_POST));

    assert_post_ignores_common_R11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_POST) |=> (phase_q != PH_MEAS));

    assert_meas_only_start_mode_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(phase_q) == PH_IDLE && phase_q == PH_MEAS) |-> !$past(stop_mode));

    assert_window_ends_or_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (win_last && !abort_now) |=> !clear_window);

    assert_conv_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (conv_last && !meas_end) |=> !conv_run);

    assert_meas_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_MEAS && !ext_timeout_sel && !meas_run) |-> meas_end);
endmodule

// File: tb/tdc_acq_sequencer_tb.sv
module tdc_acq_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        stop_mode, ext_timeout_sel;
    logic [11:0] full_scale_cfg;
    logic [8:0]  window_cfg;
    logic [10:0] hit_count;
    logic        common_in, ext_timeout_in, fast_clear_in, buf_full;
    logic        busy, clear_window, event_commit, event_abort;

    always #10 clk = ~clk;

    tdc_acq_sequencer dut_i (
        .clk             (clk),
        .rst             (rst),
        .stop_mode       (stop_mode),
        .ext_timeout_sel (ext_timeout_sel),
        .full_scale_cfg  (full_scale_cfg),
        .window_cfg      (window_cfg),
        .hit_count       (hit_count),
        .common_in       (common_in),
        .ext_timeout_in  (ext_timeout_in),
        .fast_clear_in   (fast_clear_in),
        .buf_full        (buf_full),
        .busy            (busy),
        .clear_window    (clear_window),
        .event_commit    (event_commit),
        .event_abort     (event_abort)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit    is_abort;
        int    at;
        string req;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int conv_cyc(input int h);
        int c;
        c = (1200 + 50 * h + 7) / 8;
        return (c < 219) ? 219 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic expect_evt(input bit ab, input int at, input string req);
        exp_t e;
        e.is_abort = ab;
        e.at       = at;
        e.req      = req;
        sb.push_back(e);
    endtask

    // Monitor: pops expected strobes as the design produces them
    always @(negedge clk) begin : monitor
        exp_t e;
        if (!rst && (event_commit || event_abort)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected strobe (abort=1) cycle", event_abort ? cyc : -cyc, 0);
            end else begin
                e = sb.pop_front();
                check(event_abort == e.is_abort, e.req, "strobe kind abort", int'(event_abort),
                      int'(e.is_abort));
                check(cyc == e.at, e.req, "strobe cycle", cyc, e.at);
            end
        end
    end

    // Called at a negedge; the edge is sampled at the next posedge (returned)
    task automatic pulse_common(output int t0);
        common_in = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        common_in = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        int t0, e, c, dummy;
        rst = 1'b1;
        stop_mode = 1'b0;
        ext_timeout_sel = 1'b0;
        full_scale_cfg = 12'd20;
        window_cfg = 9'd2;
        hit_count = 11'd0;
        common_in = 1'b0;
        ext_timeout_in = 1'b0;
        fast_clear_in = 1'b0;
        buf_full = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(clear_window == 1'b0, "R1", "window in reset", clear_window, 0);
        rst = 1'b0;
        @(negedge clk);
        check(event_commit == 1'b0, "R1", "commit after reset", event_commit, 0);
        check(event_abort == 1'b0, "R1", "abort after reset", event_abort, 0);

        // R2: internal full scale, then window 256 > conversion 219
        pulse_common(t0);
        e = t0 + 21;
        expect_evt(1'b0, e + 257, "R2");
        wait_to(e - 1);
        check(clear_window == 1'b0, "R2", "window before full scale", clear_window, 0);
        @(negedge clk);
        check(clear_window == 1'b1, "R2", "window at full scale", clear_window, 1);
        check(busy == 1'b1, "R5", "busy at conversion start", busy, 1);
        wait_to(e + 258);
        check(event_commit == 1'b0, "R9", "commit one cycle only", event_commit, 0);
        drain();

        // R5: long conversion, 100 hits
        hit_count = 11'd100;
        c = conv_cyc(100);
        pulse_common(t0);
        e = t0 + 21;
        expect_evt(1'b0, e + c + 1, "R5");
        wait_to(e + c - 1);
        check(busy == 1'b1, "R5", "busy last conversion cycle", busy, 1);
        @(negedge clk);
        check(busy == 1'b0, "R5", "busy after conversion", busy, 0);
        drain();

        // R6: window_cfg 0 -> one unit, 13 hits -> 232 cycles
        window_cfg = 9'd0;
        hit_count = 11'd13;
        pulse_common(t0);
        e = t0 + 21;
        expect_evt(1'b0, e + max2(conv_cyc(13), 128) + 1, "R6");
        wait_to(e + 127);
        check(clear_window == 1'b1, "R6", "cfg0 last window cycle", clear_window, 1);
        @(negedge clk);
        check(clear_window == 1'b0, "R6", "cfg0 window closed", clear_window, 0);
        drain();

        // R6 with cfg 1, R5 minimum at 11 hits
        window_cfg = 9'd1;
        hit_count = 11'd11;
        pulse_common(t0);
        e = t0 + 21;
        expect_evt(1'b0, e + 220, "R5");
        wait_to(e + 127);
        check(clear_window == 1'b1, "R6", "cfg1 last window cycle", clear_window, 1);
        @(negedge clk);
        check(clear_window == 1'b0, "R6", "cfg1 window closed", clear_window, 0);
        drain();

        // R3: external time-out, internal count ignored
        window_cfg = 9'd2;
        hit_count = 11'd0;
        ext_timeout_sel = 1'b1;
        full_scale_cfg = 12'd5;
        pulse_common(t0);
        wait_to(t0 + 40);
        check(clear_window == 1'b0, "R3", "no end on internal count", clear_window, 0);
        ext_timeout_in = 1'b1;
        e = cyc + 1;
        expect_evt(1'b0, e + 257, "R3");
        @(negedge clk);
        ext_timeout_in = 1'b0;
        check(clear_window == 1'b1, "R3", "window at ext edge", clear_window, 1);
        drain();
        ext_timeout_sel = 1'b0;
        full_scale_cfg = 12'd20;

        // R4: common stop
        stop_mode = 1'b1;
        pulse_common(t0);
        e = t0;
        expect_evt(1'b0, e + 257, "R4");
        check(clear_window == 1'b1, "R4", "window at stop edge", clear_window, 1);
        drain();

        // R7: abort mid-window, then immediate restart
        pulse_common(t0);
        e = t0;
        wait_to(e + 50);
        fast_clear_in = 1'b1;
        expect_evt(1'b1, e + 51, "R7");
        @(negedge clk);
        fast_clear_in = 1'b0;
        check(busy == 1'b0, "R7", "busy after abort", busy, 0);
        check(clear_window == 1'b0, "R7", "window after abort", clear_window, 0);
        pulse_common(t0);
        expect_evt(1'b0, t0 + 257, "R7");
        drain();

        // R7 boundary: fast clear on last window cycle (window 384)
        window_cfg = 9'd3;
        pulse_common(t0);
        e = t0;
        wait_to(e + 383);
        fast_clear_in = 1'b1;
        expect_evt(1'b1, e + 384, "R7");
        @(negedge clk);
        fast_clear_in = 1'b0;
        drain();

        // R8 boundary: fast clear one cycle after the window closed
        pulse_common(t0);
        e = t0;
        wait_to(e + 384);
        fast_clear_in = 1'b1;
        expect_evt(1'b0, e + 385, "R8");
        @(negedge clk);
        fast_clear_in = 1'b0;
        drain();

        // Same cycle: fast clear on the edge where conversion ends
        pulse_common(t0);
        e = t0;
        wait_to(e + 219 - 1);
        fast_clear_in = 1'b1;
        expect_evt(1'b1, e + 219, "R7");
        @(negedge clk);
        fast_clear_in = 1'b0;
        check(busy == 1'b0, "R7", "busy after coincident abort", busy, 0);
        drain();

        // R8: level held high from measurement into the window
        stop_mode = 1'b0;
        window_cfg = 9'd2;
        pulse_common(t0);
        fast_clear_in = 1'b1;
        e = t0 + 21;
        expect_evt(1'b0, e + 257, "R8");
        wait_to(e + 100);
        check(clear_window == 1'b1, "R8", "held level no abort", clear_window, 1);
        drain();
        fast_clear_in = 1'b0;

        // R11: common edges during measurement and window ignored
        pulse_common(t0);
        e = t0 + 21;
        expect_evt(1'b0, e + 257, "R11");
        wait_to(t0 + 5);
        pulse_common(dummy);
        wait_to(e + 30);
        pulse_common(dummy);
        drain();
        check(clear_window == 1'b0, "R11", "no restart window", clear_window, 0);
        check(busy == 1'b0, "R11", "no restart busy", busy, 0);

        // R10 / R11: buffer full
        stop_mode = 1'b1;
        buf_full = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R10", "busy when full", busy, 1);
        pulse_common(dummy);
        check(clear_window == 1'b0, "R11", "stop ignored when full", clear_window, 0);
        repeat (5) @(negedge clk);
        buf_full = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R10", "busy released", busy, 0);
        repeat (5) @(negedge clk);

        check(sb.size() == 0, "R9", "pending expected strobes", sb.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule